// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block gathers a parameterized set of level-sensitive event sources, 32 by default, and presents at most one interrupt request at a time to a CPU. Each source event is captured in a pending bit. Each line has an enable and a 3-bit priority, where 0 is the most urgent. The controller chooses the best pending, enabled line that passes the mask threshold. It then decides whether that line may interrupt the handler that is already running. Software configures the controller through a single-cycle write port. With this port it can change enables, priorities, the split of priority bits between preemption and subpriority, the masking threshold and a global gate, and it can force pending bits on or off.

On the CPU side there is a request and a line index, an acknowledge that accepts the offered line, and an end-of-handler strobe. Each acknowledge pushes the accepted line and its group level onto an internal stack of nested handlers. Each end-of-handler pops the top entry. A new line preempts only when its group level is numerically below the level at the top of the stack. A line in the same group waits and is offered straight after the running handler ends.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset no request is raised, the vector reads 0, and all pending bits and enables are off. Gate on, grouping 3 and mask 0 are the reset settings.
- R2: Write operations are selected by `wr_op`: 0 = line enable (`wr_data[0]`), 1 = line priority (`wr_data[7:5]`, low five bits ignored), 2 = grouping (`wr_data[2:0]`), 3 = mask threshold (`wr_data[7:5]`), 4 = global gate (`wr_data[0]`), 5 = set pending, 6 = clear pending. `wr_idx` selects the line for operations 0, 1, 5 and 6.
- R3: Among eligible lines the numerically lowest priority wins. On an equal priority the lowest line index wins.
- R4: A mask value M other than 0 blocks every line whose priority is M or greater. A mask of 0 blocks nothing.
- R5: With grouping value G (values of 3 or more act as 3), the group level is the top min(G,3) priority bits. A line is offered while handlers run only if its group level is strictly below the group level at the top of the stack.
- R6: A pending line that is held back because its group level equals the running group level is offered once that handler ends.
- R7: An acknowledge while the request is high clears that line's pending bit and pushes the line. An end-of-handler pops one level, and an end-of-handler with an empty stack is ignored.
- R8: A pending line whose enable is off stays pending and is offered once it is enabled. A software clear discards a pending request that has not been serviced.
- R9: When the global gate is off, no request is raised. Enables and pending bits are not changed and take effect again once the gate is back on.
- R10: A rising source level sets its pending bit. While the line is active, its source does not set the pending bit again. If the source is still high when the line's handler ends, the line becomes pending again.
- R11: The request and vector are registered and follow a state change one clock later. The request drops in the clock after an accepted acknowledge.
- R12: The stack holds up to 8 nested levels, and each pop returns to the level below it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src | input | N_SRC | Level-sensitive event sources |
| wr_en | input | 1 | Write strobe for the configuration port |
| wr_op | input | 3 | Write operation select |
| wr_idx | input | IDX_W | Target line for per-line operations |
| wr_data | input | 8 | Write data |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_vec | output | IDX_W | Index of the offered line |
| irq_ack | input | 1 | CPU accepts the offered line |
| irq_eoh | input | 1 | CPU finished the innermost handler |

## Verification
The bench builds the controller with 8 sources and the default stack depth of 8. At this size the tests can sweep every priority against every mask value and every priority pair for two competing lines. They also cover every pair of running and arriving priorities under grouping values 0, 1, 2, 3 and an out-of-range 6. Eight lines with distinct priorities are enough to fill the stack completely and then unwind it to the empty state.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int PRIO_W = 3;

  typedef logic [PRIO_W-1:0] prio_t;

  typedef enum logic [2:0] {
    OP_ENABLE = 3'd0,
    OP_PRIO   = 3'd1,
    OP_GROUP  = 3'd2,
    OP_MASK   = 3'd3,
    OP_GATE   = 3'd4,
    OP_PSET   = 3'd5,
    OP_PCLR   = 3'd6,
    OP_NONE   = 3'd7
  } wr_op_e;

  // Bits of a priority that form the preempting group level.
  function automatic prio_t group_mask(input logic [2:0] gbits);
    int    keep;
    prio_t m;
    keep = (gbits >= 3'd3) ? PRIO_W : int'(gbits);
    m = '0;
    for (int b = 0; b < PRIO_W; b++) begin
      if (b >= PRIO_W - keep) m[b] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/pic_pending.sv
module pic_pending #(
  parameter int N_SRC = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] src,
  input  logic [N_SRC-1:0] active,
  input  logic [N_SRC-1:0] rearm,
  input  logic [N_SRC-1:0] sw_set,
  input  logic [N_SRC-1:0] sw_clr,
  input  logic [N_SRC-1:0] ack_clr,
  output logic [N_SRC-1:0] pend
);
  logic [N_SRC-1:0] src_q;

  always_ff @(posedge clk) begin
    if (rst) src_q <= '0;
    else     src_q <= src;
  end

  for (genvar i = 0; i < N_SRC; i++) begin : g_line
    logic hw_set;
    assign hw_set = src[i] & ~active[i] & (~src_q[i] | rearm[i]);

    always_ff @(posedge clk) begin
      if (rst)            pend[i] <= 1'b0;
      else if (sw_clr[i]) pend[i] <= 1'b0;
      else if (ack_clr[i]) pend[i] <= 1'b0;
      else if (hw_set | sw_set[i]) pend[i] <= 1'b1;
    end
  end
endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter
  import pic_pkg::*;
#(
  parameter int N_SRC = 32,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0]             pend,
  input  logic [N_SRC-1:0]             en,
  input  logic [N_SRC-1:0][PRIO_W-1:0] prio,
  input  prio_t                        mask,
  output logic                         win_valid,
  output logic [IDX_W-1:0]             win_idx,
  output prio_t                        win_prio
);
  logic [N_SRC-1:0] elig;

  for (genvar i = 0; i < N_SRC; i++) begin : g_elig
    assign elig[i] = pend[i] & en[i] & ((mask == '0) | (prio[i] < mask));
  end

  // Strict compare keeps the lowest index on a tie.
  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    win_prio  = '1;
    for (int i = 0; i < N_SRC; i++) begin
      if (elig[i] && (!win_valid || prio[i] < win_prio)) begin
        win_valid = 1'b1;
        win_idx   = IDX_W'(i);
        win_prio  = prio[i];
      end
    end
  end
endmodule

// File: rtl/pic_stack.sv
module pic_stack
  import pic_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int IDX_W = 5,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int DW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             pop,
  input  prio_t            push_grp,
  input  logic [IDX_W-1:0] push_idx,
  output logic             empty,
  output logic             full,
  output prio_t            top_grp,
  output logic [IDX_W-1:0] top_idx,
  output logic [DW-1:0]    depth
);
  prio_t            grp_mem [DEPTH];
  logic [IDX_W-1:0] idx_mem [DEPTH];
  logic [DW-1:0]    sp_q;
  logic [PW-1:0]    wr_ptr;
  logic [PW-1:0]    rd_ptr;

  assign wr_ptr = PW'(sp_q);
  assign rd_ptr = PW'(sp_q - 1'b1);
  assign empty  = (sp_q == '0);
  assign full   = (sp_q == DW'(DEPTH));
  assign depth  = sp_q;

  always_ff @(posedge clk) begin
    if (push && !full) begin
      grp_mem[wr_ptr] <= push_grp;
      idx_mem[wr_ptr] <= push_idx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                 sp_q <= '0;
    else if (push && !full)  sp_q <= sp_q + 1'b1;
    else if (pop && !empty)  sp_q <= sp_q - 1'b1;
  end

  assign top_grp = empty ? '1 : grp_mem[rd_ptr];
  assign top_idx = empty ? '0 : idx_mem[rd_ptr];
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pic_pkg::*;
#(
  parameter int N_SRC   = 32,
  parameter int STACK_D = 8,
  localparam int IDX_W  = (N_SRC > 1) ? $clog2(N_SRC) : 1,
  localparam int DW     = $clog2(STACK_D + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] src,
  input  logic             wr_en,
  input  logic [2:0]       wr_op,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [7:0]       wr_data,
  output logic             irq_req,
  output logic [IDX_W-1:0] irq_vec,
  input  logic             irq_ack,
  input  logic             irq_eoh
);
  wr_op_e                       op;
  logic                         idx_ok;
  logic [N_SRC-1:0]             en_q;
  logic [N_SRC-1:0][PRIO_W-1:0] prio_q;
  logic [2:0]                   grp_q;
  prio_t                        mask_q;
  logic                         gate_q;
  logic [N_SRC-1:0]             active_q;
  logic [N_SRC-1:0]             rearm_q;
  logic [N_SRC-1:0]             pend_q;
  logic [N_SRC-1:0]             sw_set, sw_clr, ack_clr;
  logic                         ack_fire, pop_fire;
  logic                         win_valid;
  logic [IDX_W-1:0]             win_idx;
  prio_t                        win_prio, win_grp, gmask;
  logic                         stk_empty, stk_full;
  prio_t                        top_grp;
  logic [IDX_W-1:0]             top_idx;
  logic [DW-1:0]                stk_depth;
  logic                         may_preempt;
  logic                         req_d;
  logic                         unused_bits;

  assign op          = wr_op_e'(wr_op);
  assign idx_ok      = (int'(wr_idx) < N_SRC);
  assign unused_bits = ^wr_data[4:3];

  // Configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      prio_q <= '0;
      grp_q  <= 3'd3;
      mask_q <= '0;
      gate_q <= 1'b1;
    end else if (wr_en) begin
      case (op)
        OP_ENABLE: if (idx_ok) en_q[wr_idx]   <= wr_data[0];
        OP_PRIO:   if (idx_ok) prio_q[wr_idx] <= wr_data[7:5];
        OP_GROUP:  grp_q  <= wr_data[2:0];
        OP_MASK:   mask_q <= wr_data[7:5];
        OP_GATE:   gate_q <= wr_data[0];
        default:   ;
      endcase
    end
  end

  assign ack_fire = irq_ack & irq_req;
  assign pop_fire = irq_eoh & ~stk_empty & ~ack_fire;

  always_comb begin
    sw_set  = '0;
    sw_clr  = '0;
    ack_clr = '0;
    if (wr_en && idx_ok && op == OP_PSET) sw_set[wr_idx] = 1'b1;
    if (wr_en && idx_ok && op == OP_PCLR) sw_clr[wr_idx] = 1'b1;
    if (ack_fire) ack_clr[irq_vec] = 1'b1;
  end

  // Lines currently being serviced, and the re-arm pulse after their end
  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= '0;
      rearm_q  <= '0;
    end else begin
      rearm_q <= '0;
      if (pop_fire) begin
        active_q[top_idx] <= 1'b0;
        rearm_q[top_idx]  <= 1'b1;
      end
      if (ack_fire) active_q[irq_vec] <= 1'b1;
    end
  end

  pic_pending #(.N_SRC(N_SRC)) u_pend (
    .clk     (clk),
    .rst     (rst),
    .src     (src),
    .active  (active_q),
    .rearm   (rearm_q),
    .sw_set  (sw_set),
    .sw_clr  (sw_clr),
    .ack_clr (ack_clr),
    .pend    (pend_q)
  );

  pic_arbiter #(.N_SRC(N_SRC)) u_arb (
    .pend      (pend_q),
    .en        (en_q),
    .prio      (prio_q),
    .mask      (mask_q),
    .win_valid (win_valid),
    .win_idx   (win_idx),
    .win_prio  (win_prio)
  );

  assign gmask   = group_mask(grp_q);
  assign win_grp = win_prio & gmask;

  pic_stack #(.DEPTH(STACK_D), .IDX_W(IDX_W)) u_stk (
    .clk      (clk),
    .rst      (rst),
    .push     (ack_fire),
    .pop      (pop_fire),
    .push_grp (win_grp_at_ack()),
    .push_idx (irq_vec),
    .empty    (stk_empty),
    .full     (stk_full),
    .top_grp  (top_grp),
    .top_idx  (top_idx),
    .depth    (stk_depth)
  );

  // Group level of the accepted line, from its stored priority.
  function automatic prio_t win_grp_at_ack();
    return prio_q[irq_vec] & gmask;
  endfunction

  assign may_preempt = stk_empty | (win_grp < top_grp);
  assign req_d       = gate_q & win_valid & may_preempt & ~stk_full & ~ack_fire;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req <= 1'b0;
      irq_vec <= '0;
    end else begin
      irq_req <= req_d;
      irq_vec <= win_idx;
    end
  end
endmodule

// File: rtl/pic_checker.sv
module pic_checker #(
  parameter int N_SRC   = 32,
  parameter int STACK_D = 8,
  parameter int IDX_W   = 5,
  parameter int DW      = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             irq_req,
  input logic [IDX_W-1:0] irq_vec,
  input logic             irq_ack,
  input logic             irq_eoh,
  input logic             gate_q,
  input logic [N_SRC-1:0] pend_q,
  input logic [N_SRC-1:0] en_q,
  input logic [DW-1:0]    stk_depth
);
  logic [N_SRC-1:0] pend_prev, en_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_prev <= '0;
      en_prev   <= '0;
    end else begin
      pend_prev <= pend_q;
      en_prev   <= en_q;
    end
  end

  // R9
  gate_off_chk: assert property (@(posedge clk) disable iff (rst)
    !gate_q |=> !irq_req);

  // R7
  ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && irq_req) |=> !pend_q[$past(irq_vec)]);

  // R7
  push_step_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && irq_req) |=> (stk_depth == $past(stk_depth) + 1'b1));

  // R11
  req_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && irq_req) |=> !irq_req);

  // R8
  req_source_chk: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (pend_prev[irq_vec] && en_prev[irq_vec]));

  // R12
  depth_bound_chk: assert property (@(posedge clk) disable iff (rst)
    int'(stk_depth) <= STACK_D);

  // R7
  empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_eoh && !irq_ack && stk_depth == '0) |=> (stk_depth == '0));
endmodule

bind prio_irq_ctrl pic_checker #(
  .N_SRC   (N_SRC),
  .STACK_D (STACK_D),
  .IDX_W   (IDX_W),
  .DW      (DW)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .irq_req   (irq_req),
  .irq_vec   (irq_vec),
  .irq_ack   (irq_ack),
  .irq_eoh   (irq_eoh),
  .gate_q    (gate_q),
  .pend_q    (pend_q),
  .en_q      (en_q),
  .stk_depth (stk_depth)
);

// File: tb/sim_prio_irq_ctrl.sv
module sim_prio_irq_ctrl;
  localparam int N = 8;
  localparam logic [2:0] OPC_EN = 3'd0, OPC_PRIO = 3'd1, OPC_GRP = 3'd2,
                         OPC_MASK = 3'd3, OPC_GATE = 3'd4, OPC_PSET = 3'd5,
                         OPC_PCLR = 3'd6;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [N-1:0] src = '0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_op = '0;
  logic [2:0] wr_idx = '0;
  logic [7:0] wr_data = '0;
  logic       irq_req;
  logic [2:0] irq_vec;
  logic       irq_ack = 1'b0;
  logic       irq_eoh = 1'b0;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  prio_irq_ctrl #(.N_SRC(N), .STACK_D(8)) u0 (
    .clk(clk), .rst(rst), .src(src), .wr_en(wr_en), .wr_op(wr_op),
    .wr_idx(wr_idx), .wr_data(wr_data), .irq_req(irq_req), .irq_vec(irq_vec),
    .irq_ack(irq_ack), .irq_eoh(irq_eoh)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic settle();
    tick();
    tick();
  endtask

  task automatic do_reset();
    rst = 1'b1;
    src = '0;
    tick();
    tick();
    rst = 1'b0;
  endtask

  task automatic wr(input logic [2:0] op, input int idx, input logic [7:0] d);
    wr_en = 1'b1; wr_op = op; wr_idx = idx[2:0]; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic do_ack();
    irq_ack = 1'b1;
    tick();
    irq_ack = 1'b0;
  endtask

  task automatic do_eoh();
    irq_eoh = 1'b1;
    tick();
    irq_eoh = 1'b0;
  endtask

  function automatic int obs();
    return irq_req ? int'(irq_vec) : -1;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int glevel(input int p, input int g);
    int keep;
    keep = (g >= 3) ? 3 : g;
    return (keep == 0) ? 0 : (p >> (3 - keep));
  endfunction

  function automatic logic [7:0] pf(input int p, input logic [4:0] junk);
    return {p[2:0], junk};
  endfunction

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int gsel [5] = '{0, 1, 2, 3, 6};

    // R1 reset state
    do_reset();
    settle();
    check("R1 no request after reset", obs(), -1);
    check("R1 vector after reset", int'(irq_vec), 0);
    wr(OPC_PSET, 0, 8'h00);
    settle();
    check("R1 enables off after reset", obs(), -1);

    // R2 R4 mask sweep with junk low bits
    for (int p = 0; p < 8; p++) begin
      for (int m = 0; m < 8; m++) begin
        do_reset();
        wr(OPC_PRIO, 3, pf(p, 5'h1f));
        wr(OPC_MASK, 0, pf(m, 5'h0a));
        wr(OPC_EN, 3, 8'h01);
        wr(OPC_PSET, 3, 8'h00);
        settle();
        check($sformatf("R4 R2 mask=%0d prio=%0d", m, p), obs(),
              (m == 0 || p < m) ? 3 : -1);
      end
    end

    // R2 low bits ignored in priority order
    do_reset();
    wr(OPC_PRIO, 0, 8'h40);
    wr(OPC_PRIO, 1, 8'h3f);
    wr(OPC_EN, 0, 8'h01); wr(OPC_EN, 1, 8'h01);
    wr(OPC_PSET, 0, 8'h00); wr(OPC_PSET, 1, 8'h00);
    settle();
    check("R2 priority from top bits", obs(), 1);

    // R3 pairwise arbitration sweep
    for (int pa = 0; pa < 8; pa++) begin
      for (int pb = 0; pb < 8; pb++) begin
        do_reset();
        wr(OPC_PRIO, 2, pf(pa, 5'h00));
        wr(OPC_PRIO, 5, pf(pb, 5'h00));
        wr(OPC_EN, 2, 8'h01); wr(OPC_EN, 5, 8'h01);
        wr(OPC_PSET, 5, 8'h00); wr(OPC_PSET, 2, 8'h00);
        settle();
        check($sformatf("R3 pa=%0d pb=%0d", pa, pb), obs(), (pb < pa) ? 5 : 2);
      end
    end

    // R5 R6 R7 preemption by grouping
    for (int gi = 0; gi < 5; gi++) begin
      for (int pr = 0; pr < 8; pr++) begin
        for (int pn = 0; pn < 8; pn++) begin
          int g;
          bit pre;
          g = gsel[gi];
          pre = glevel(pn, g) < glevel(pr, g);
          do_reset();
          wr(OPC_GRP, 0, 8'(g));
          wr(OPC_PRIO, 0, pf(pr, 5'h00));
          wr(OPC_PRIO, 1, pf(pn, 5'h00));
          wr(OPC_EN, 0, 8'h01); wr(OPC_EN, 1, 8'h01);
          wr(OPC_PSET, 0, 8'h00);
          settle();
          check("R7 first line offered", obs(), 0);
          do_ack();
          wr(OPC_PSET, 1, 8'h00);
          settle();
          check($sformatf("R5 g=%0d run=%0d new=%0d", g, pr, pn), obs(), pre ? 1 : -1);
          if (pre) begin
            do_ack();
            do_eoh();
            settle();
            check("R7 pop back to running line", obs(), -1);
            do_eoh();
          end else begin
            do_eoh();
            settle();
            check($sformatf("R6 tail chain g=%0d", g), obs(), 1);
            do_ack();
            do_eoh();
          end
          settle();
          check("R7 idle after unwind", obs(), -1);
        end
      end
    end

    // R7 end-of-handler with empty stack ignored
    do_reset();
    do_eoh();
    wr(OPC_EN, 4, 8'h01);
    wr(OPC_PSET, 4, 8'h00);
    settle();
    check("R7 empty pop ignored", obs(), 4);

    // R8 disabled pending, then enable, then software clear
    do_reset();
    wr(OPC_PSET, 6, 8'h00);
    settle();
    check("R8 disabled line held", obs(), -1);
    wr(OPC_EN, 6, 8'h01);
    settle();
    check("R8 delivered on enable", obs(), 6);
    wr(OPC_PCLR, 6, 8'h00);
    settle();
    check("R8 software clear discards", obs(), -1);

    // R9 global gate
    do_reset();
    wr(OPC_EN, 2, 8'h01);
    wr(OPC_GATE, 0, 8'h00);
    wr(OPC_PSET, 2, 8'h00);
    settle();
    check("R9 gate off blocks", obs(), -1);
    wr(OPC_GATE, 0, 8'h01);
    settle();
    check("R9 gate on restores", obs(), 2);

    // R10 source edge and re-arm
    do_reset();
    wr(OPC_EN, 4, 8'h01);
    src[4] = 1'b1;
    settle();
    check("R10 rise sets pending", obs(), 4);
    do_ack();
    settle();
    check("R10 held source while active", obs(), -1);
    do_eoh();
    settle();
    check("R10 re-pend after handler end", obs(), 4);
    do_ack();
    src[4] = 1'b0;
    do_eoh();
    settle();
    check("R10 low source no re-pend", obs(), -1);

    // R11 latency and drop after acknowledge
    do_reset();
    wr(OPC_EN, 1, 8'h01);
    wr(OPC_PSET, 1, 8'h00);
    check("R11 not yet visible", obs(), -1);
    tick();
    check("R11 visible one clock later", obs(), 1);
    do_ack();
    check("R11 dropped after ack", obs(), -1);

    // R12 fill the stack with eight levels, then unwind
    do_reset();
    for (int i = 0; i < 8; i++) begin
      wr(OPC_PRIO, i, pf(7 - i, 5'h00));
      wr(OPC_EN, i, 8'h01);
    end
    for (int i = 0; i < 8; i++) begin
      wr(OPC_PSET, i, 8'h00);
      settle();
      check($sformatf("R12 nest level %0d", i), obs(), i);
      do_ack();
    end
    wr(OPC_PSET, 0, 8'h00);
    settle();
    check("R12 full stack no request", obs(), -1);
    for (int i = 0; i < 7; i++) do_eoh();
    settle();
    check("R12 same level still running", obs(), -1);
    do_eoh();
    settle();
    check("R12 delivered after full unwind", obs(), 0);

    summary();
  end
endmodule